// File: doc/BRIEF.md
# Serial Converter Conversion Sequencer

This block is the host side of a two-wire link to a sigma-delta converter. The link has one clock line driven by the host and one data line driven by the converter. When a request arrives, the sequencer latches a 2-bit channel number, a requested resolution and its timing settings. It starts a conversion with one falling clock edge. It then sends one extra falling edge for each bit of resolution it wants to drop, and these edges follow straight after the start edge so that they land inside the converter's reduction window.

After the last of these edges the sequencer holds the clock high and waits for the converter to raise the data line, which marks the end of the conversion. It then clocks the result in, sign bit first. The result is presented as a 16-bit two's-complement word with the unused low bits cleared, together with a one-cycle valid strobe. A watchdog ends the wait if the converter never finishes. The clock half-period and the point at which data is sampled are both counted in system clock cycles.

Top module: `adc_seq_host`

## Requirements
- R1: Out of reset and whenever no transaction is in progress, `sclk_o` is high and `busy_o` is low.
- R2: A request is accepted only when `busy_o` is low. On acceptance, `sclk_o` goes low in the next cycle. A request made while busy has no effect on the channel or the result of the transaction in progress.
- R3: Every low phase and every high phase of `sclk_o` lasts exactly D cycles, where D is `div_i` latched at acceptance, with 0 treated as 1.
- R4: The effective resolution is `res_i` clamped to the range 10 to 16. Straight after the start pulse, exactly 16 minus that resolution reduction pulses are sent, so there are never more than six.
- R5: After the start and reduction pulses, `sclk_o` stays high until `sdat_i` is seen high on a clock edge. The first data pulse begins in the cycle after that edge.
- R6: During each data pulse, `sdat_i` is sampled once, at low-phase cycle index min(`settle_i`, D-1), counting from 0. `settle_i` is latched at acceptance.
- R7: Every completed transaction has exactly 17 falling edges of `sclk_o`: one start edge, the reduction edges and one edge per data bit.
- R8: The first received bit lands in bit 15 of `data_o` and later bits fill downward. Bits below the effective resolution are zero. `data_vld_o` is high for one cycle, with `chan_o` equal to the accepted channel.
- R9: `rsvd_o` is high, together with `data_vld_o`, exactly when the received word is a set sign bit followed by all zeros. With the word left-justified this means `data_o` equals 16'h8000.
- R10: If `sdat_i` stays low for TMO_CYCLES consecutive wait cycles, `tmo_o` pulses for one cycle and the block returns to idle with `sclk_o` high and no `data_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Conversion request, one cycle |
| chan_i | input | 2 | Channel number for the request |
| res_i | input | 5 | Requested resolution in bits |
| div_i | input | DIV_W | SCLK half-period in system cycles |
| settle_i | input | SET_W | Sample offset within the low phase |
| sclk_o | output | 1 | Serial clock to the converter |
| sdat_i | input | 1 | Serial data and status from the converter |
| busy_o | output | 1 | Transaction in progress |
| data_o | output | 16 | Left-justified two's-complement result |
| data_vld_o | output | 1 | One-cycle result strobe |
| rsvd_o | output | 1 | Reserved code received, with the strobe |
| chan_o | output | 2 | Channel of the delivered result |
| tmo_o | output | 1 | One-cycle completion timeout pulse |

## Verification
Some properties hold on every cycle and are checked as assertions. Idle SCLK is high. The clock does not fall while completion is still pending. The falling-edge count is capped and comes to seventeen exactly when the valid strobe fires. The low bits of the result are zero, the reserved flag agrees with the word, and the result strobe and the timeout pulse are exclusive. Other behaviour can only be shown by the bench's scenarios, where a behavioural converter model answers the pulses. These are the exact phase lengths for each divider, the sampling offset, clamping of out-of-range resolutions, reassembly of the bit order, a request ignored mid-transaction, and recovery after a timeout.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int WORD_W  = 16;
  localparam int RES_W   = 5;
  localparam int RES_MIN = 10;
  localparam int RES_MAX = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_WAIT} seq_st_t;

  // clamp a requested resolution into the supported window
  function automatic logic [RES_W-1:0] clamp_res(input logic [RES_W-1:0] r);
    if (int'(r) < RES_MIN) return RES_W'(RES_MIN);
    if (int'(r) > RES_MAX) return RES_W'(RES_MAX);
    return r;
  endfunction

  // raw word holds r bits in its LSBs; move the first bit to the MSB
  function automatic logic [WORD_W-1:0] justify(input logic [WORD_W-1:0] raw,
                                                input logic [RES_W-1:0] r);
    return raw << (RES_W'(WORD_W) - r);
  endfunction

  // sign bit set and every other received bit clear
  function automatic logic is_reserved(input logic [WORD_W-1:0] raw,
                                       input logic [RES_W-1:0] r);
    return raw == (WORD_W'(1) << (r - RES_W'(1)));
  endfunction
endpackage

// File: rtl/adc_seq_phase.sv
`timescale 1ns/1ps
module adc_seq_phase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] last_idx,
  input  logic [CNT_W-1:0] smp_idx,
  output logic             ph_end,
  output logic             smp_hit
);
  logic [CNT_W-1:0] cnt;

  assign ph_end  = run && (cnt == last_idx);
  assign smp_hit = run && (cnt == smp_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || ph_end)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_shift.sv
`timescale 1ns/1ps
module adc_seq_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/adc_seq_wdog.sv
`timescale 1ns/1ps
module adc_seq_wdog #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_seq_host.sv
`timescale 1ns/1ps
module adc_seq_host
  import adc_seq_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int SET_W      = 8,
  parameter int TMO_CYCLES = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [1:0]         chan_i,
  input  logic [RES_W-1:0]   res_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [SET_W-1:0]   settle_i,
  output logic               sclk_o,
  input  logic               sdat_i,
  output logic               busy_o,
  output logic [WORD_W-1:0]  data_o,
  output logic               data_vld_o,
  output logic               rsvd_o,
  output logic [1:0]         chan_o,
  output logic               tmo_o
);
  seq_st_t state;
  logic [DIV_W-1:0]  last_q, smp_q;
  logic [RES_W-1:0]  res_q, bits_left;
  logic [2:0]        red_left;
  logic [1:0]        chan_q;
  logic              kind_data;

  // named internal events
  logic st_idle, st_low, st_high, st_wait;
  logic ev_accept, ev_shift, ph_end, smp_hit, wd_expired;
  logic [WORD_W-1:0] raw_q;

  assign st_idle   = (state == ST_IDLE);
  assign st_low    = (state == ST_LOW);
  assign st_high   = (state == ST_HIGH);
  assign st_wait   = (state == ST_WAIT);
  assign ev_accept = st_idle && req_i;
  assign ev_shift  = st_low && kind_data && smp_hit;

  assign sclk_o = !st_low;
  assign busy_o = !st_idle;

  adc_seq_phase #(.CNT_W(DIV_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(st_low || st_high),
    .last_idx(last_q), .smp_idx(smp_q), .ph_end(ph_end), .smp_hit(smp_hit)
  );

  adc_seq_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(ev_accept), .en(ev_shift),
    .din(sdat_i), .q(raw_q)
  );

  adc_seq_wdog #(.LIMIT(TMO_CYCLES)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run(st_wait), .expired(wd_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      last_q     <= '0;
      smp_q      <= '0;
      res_q      <= RES_W'(RES_MAX);
      bits_left  <= '0;
      red_left   <= '0;
      chan_q     <= '0;
      kind_data  <= 1'b0;
      data_o     <= '0;
      data_vld_o <= 1'b0;
      rsvd_o     <= 1'b0;
      chan_o     <= '0;
      tmo_o      <= 1'b0;
    end else begin
      data_vld_o <= 1'b0;
      rsvd_o     <= 1'b0;
      tmo_o      <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_i) begin
          chan_q    <= chan_i;
          res_q     <= clamp_res(res_i);
          bits_left <= clamp_res(res_i);
          red_left  <= 3'(RES_W'(RES_MAX) - clamp_res(res_i));
          last_q    <= (div_i == '0) ? '0 : div_i - 1'b1;
          if (div_i == '0)                       smp_q <= '0;
          else if (int'(settle_i) >= int'(div_i)) smp_q <= div_i - 1'b1;
          else                                    smp_q <= DIV_W'(settle_i);
          kind_data <= 1'b0;
          state     <= ST_LOW;
        end
        ST_LOW: begin
          if (ev_shift) bits_left <= bits_left - 1'b1;
          if (ph_end)   state     <= ST_HIGH;
        end
        ST_HIGH: if (ph_end) begin
          if (!kind_data) begin
            if (red_left != '0) begin
              red_left <= red_left - 1'b1;
              state    <= ST_LOW;
            end else begin
              state    <= ST_WAIT;
            end
          end else if (bits_left != '0) begin
            state <= ST_LOW;
          end else begin
            data_o     <= justify(raw_q, res_q);
            rsvd_o     <= is_reserved(raw_q, res_q);
            data_vld_o <= 1'b1;
            chan_o     <= chan_q;
            state      <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (sdat_i) begin
            kind_data <= 1'b1;
            state     <= ST_LOW;
          end else if (wd_expired) begin
            tmo_o <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_host_chk.sv
`timescale 1ns/1ps
module adc_seq_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_i,
  input logic        sdat_i,
  input logic        sclk_o,
  input logic        busy_o,
  input logic [15:0] data_o,
  input logic        data_vld_o,
  input logic        rsvd_o,
  input logic        tmo_o,
  input logic        st_wait,
  input logic [4:0]  res_q,
  input logic [1:0]  chan_q
);
  logic       sclk_d;
  logic [4:0] fall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b1;
      fall_cnt <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (!busy_o)                fall_cnt <= '0;
      else if (sclk_d && !sclk_o) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> sclk_o); // R1
  AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_i) |=> !sclk_o); // R2
  AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(chan_q)); // R2
  AST_RES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (res_q >= 5'd10 && res_q <= 5'd16)); // R4
  AST_NO_CLOCK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && !sdat_i) |=> sclk_o); // R5
  AST_EDGE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt <= 5'd17); // R7
  AST_SEVENTEEN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld_o |-> fall_cnt == 5'd17); // R7
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld_o |-> (data_o & (16'hFFFF >> res_q)) == 16'h0000); // R8
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld_o |=> !data_vld_o); // R8
  AST_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_o |-> (data_vld_o && data_o == 16'h8000)); // R9
  AST_TMO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> (!busy_o && !data_vld_o && sclk_o)); // R10
endmodule

bind adc_seq_host adc_seq_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .sdat_i(sdat_i), .sclk_o(sclk_o),
  .busy_o(busy_o), .data_o(data_o), .data_vld_o(data_vld_o), .rsvd_o(rsvd_o),
  .tmo_o(tmo_o), .st_wait(st_wait), .res_q(res_q), .chan_q(chan_q)
);

// File: tb/adc_seq_host_bench.sv
`timescale 1ns/1ps
module adc_seq_host_bench;
  localparam int TMO      = 4096;
  localparam int WIN_LEN  = 100;
  localparam int CONV_LEN = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_i = 1'b0;
  logic [1:0] chan_i = '0;
  logic [4:0] res_i = 5'd16;
  logic [7:0] div_i = 8'd2, settle_i = 8'd1;
  logic sclk_o, sdat_i, busy_o, data_vld_o, rsvd_o, tmo_o;
  logic [15:0] data_o;
  logic [1:0] chan_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_seq_host #(.DIV_W(8), .SET_W(8), .TMO_CYCLES(TMO)) u_adc_seq_host (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .chan_i(chan_i), .res_i(res_i),
    .div_i(div_i), .settle_i(settle_i), .sclk_o(sclk_o), .sdat_i(sdat_i),
    .busy_o(busy_o), .data_o(data_o), .data_vld_o(data_vld_o), .rsvd_o(rsvd_o),
    .chan_o(chan_o), .tmo_o(tmo_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_res(input logic [4:0] r);
    if (r < 10) return 10;
    if (r > 16) return 16;
    return int'(r);
  endfunction

  // ---------------- behavioural converter ----------------
  logic [15:0] conv_code = '0;
  bit conv_stuck = 0, conv_rst = 0;
  int conv_viol = 0;
  int c_st = 0, c_t = 0, c_nred = 0, c_idx = 0;  // 0 sleep,1 window,2 busy,3 read
  logic c_prev = 1'b1;
  always @(posedge clk) begin
    c_prev <= sclk_o;
    if (!rst_n || conv_rst) begin
      c_st <= 0; sdat_i <= 1'b1;
    end else begin
      case (c_st)
        0: if (c_prev && !sclk_o) begin c_st <= 1; c_t <= 0; c_nred <= 0; sdat_i <= 1'b0; end
        1: begin
          c_t <= c_t + 1;
          if (c_prev && !sclk_o && c_nred < 6) begin c_nred <= c_nred + 1; sdat_i <= 1'b1; end
          if (!c_prev && sclk_o) sdat_i <= 1'b0;
          if (c_t == WIN_LEN) begin c_st <= 2; c_t <= 0; sdat_i <= 1'b0; end
        end
        2: begin
          if (c_prev && !sclk_o) conv_viol <= conv_viol + 1;
          c_t <= c_t + 1;
          if (!conv_stuck && c_t == (CONV_LEN >> c_nred)) begin
            c_st <= 3; c_idx <= 0; sdat_i <= 1'b1;
          end
        end
        default: begin
          if (c_prev && !sclk_o) begin sdat_i <= conv_code[15 - c_idx]; c_idx <= c_idx + 1; end
          if (!c_prev && sclk_o && c_idx == 16 - c_nred) begin sdat_i <= 1'b1; c_st <= 0; end
        end
      endcase
    end
  end

  // ---------------- cycle reference model ----------------
  logic exp_sclk = 1'b1, exp_busy = 1'b0, exp_vld = 1'b0, exp_tmo = 1'b0;
  bit model_on = 0;
  initial begin : ref_model
    bit seen, ok;
    int d, r, k;
    @(posedge rst_n);
    model_on = 1;
    forever begin
      @(posedge clk);
      seen = req_i;
      #1; exp_vld = 1'b0; exp_tmo = 1'b0;
      if (seen) begin
        d = (div_i == 0) ? 1 : int'(div_i);
        r = eff_res(res_i);
        exp_busy = 1'b1;
        for (int p = 0; p < 17 - r; p++) begin
          exp_sclk = 1'b0; repeat (d) @(posedge clk); #1;
          exp_sclk = 1'b1; repeat (d) @(posedge clk); #1;
        end
        k = 0; ok = 0;
        while (1) begin
          @(posedge clk);
          if (sdat_i) begin ok = 1; break; end
          k++;
          if (k == TMO) break;
        end
        #1;
        if (!ok) begin
          exp_busy = 1'b0; exp_tmo = 1'b1;
        end else begin
          for (int b = 0; b < r; b++) begin
            exp_sclk = 1'b0; repeat (d) @(posedge clk); #1;
            exp_sclk = 1'b1; repeat (d) @(posedge clk); #1;
          end
          exp_busy = 1'b0; exp_vld = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && model_on && !done) begin
    chk(sclk_o === exp_sclk, "R3 R5 sclk timing", int'(sclk_o), int'(exp_sclk));
    chk(busy_o === exp_busy, "R1 R2 busy", int'(busy_o), int'(exp_busy));
    chk(data_vld_o === exp_vld, "R8 valid strobe", int'(data_vld_o), int'(exp_vld));
    chk(tmo_o === exp_tmo, "R10 timeout pulse", int'(tmo_o), int'(exp_tmo));
  end

  // ---------------- result capture ----------------
  bit got_vld = 0, got_tmo = 0, got_rsvd = 0;
  logic [15:0] got_data = '0;
  logic [1:0] got_chan = '0;
  int falls = 0;
  logic b_prev = 1'b1;
  always @(negedge clk) begin
    b_prev <= sclk_o;
    if (b_prev && !sclk_o) falls <= falls + 1;
    if (data_vld_o) begin got_vld <= 1; got_data <= data_o; got_rsvd <= rsvd_o; got_chan <= chan_o; end
    if (tmo_o) got_tmo <= 1;
  end

  task automatic run_conv(input logic [1:0] ch, input logic [4:0] r, input logic [7:0] dv,
                          input logic [7:0] st, input logic [15:0] code, input bit stuck,
                          input bit poke);
    int er;
    logic [15:0] exp;
    er = eff_res(r);
    exp = code & ~(16'hFFFF >> er);
    conv_code = code; conv_stuck = stuck;
    @(negedge clk);
    got_vld = 0; got_tmo = 0; falls = 0;
    req_i = 1'b1; chan_i = ch; res_i = r; div_i = dv; settle_i = st;
    @(negedge clk);
    req_i = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      req_i = 1'b1; chan_i = ~ch; res_i = 5'd16;   // R2: must be ignored
      @(negedge clk);
      req_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(conv_viol == 0, "R5 no edge while converting", conv_viol, 0);
    if (stuck) begin
      chk(got_tmo && !got_vld, "R10 timeout without result", int'(got_vld), 0);
      chk(sclk_o == 1'b1, "R10 sclk high after timeout", int'(sclk_o), 1);
      chk(falls == 17 - er, "R4 reduction edges before timeout", falls, 17 - er);
      conv_rst = 1; @(negedge clk); conv_rst = 0;
    end else begin
      chk(got_vld && !got_tmo, "R8 result delivered", int'(got_vld), 1);
      chk(got_data == exp, "R6 R8 result word", int'(got_data), int'(exp));
      chk(got_chan == ch, "R2 R8 channel tag", int'(got_chan), int'(ch));
      chk(got_rsvd == (exp == 16'h8000), "R9 reserved flag", int'(got_rsvd), int'(exp == 16'h8000));
      chk(falls == 17, "R7 falling edge total", falls, 17);
      chk(c_nred == 16 - er, "R4 reductions seen by converter", c_nred, 16 - er);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(sclk_o == 1'b1, "R1 reset sclk", int'(sclk_o), 1);
    chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
    chk(data_vld_o == 1'b0, "R1 reset valid", int'(data_vld_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_conv(2'd1, 5'd16, 8'd2, 8'd1, 16'h5A3C, 0, 0);
    run_conv(2'd2, 5'd12, 8'd3, 8'd2, 16'hC3A5, 0, 1);
    run_conv(2'd3, 5'd10, 8'd4, 8'd9, 16'h7FFF, 0, 0);   // R6 settle clamped to D-1
    run_conv(2'd0, 5'd5,  8'd2, 8'd1, 16'h803F, 0, 0);   // R4 clamp up, R9 reserved
    run_conv(2'd1, 5'd20, 8'd2, 8'd1, 16'h8001, 0, 0);   // R4 clamp down
    run_conv(2'd2, 5'd16, 8'd2, 8'd1, 16'h8000, 0, 0);   // R9 reserved at full width
    run_conv(2'd0, 5'd13, 8'd0, 8'd0, 16'h1111, 1, 0);   // R10 with D=1 (R3)
    run_conv(2'd3, 5'd14, 8'd2, 8'd1, 16'h1235, 0, 0);   // recovery
    chk(sclk_o == 1'b1 && !busy_o, "R1 idle at end", int'(sclk_o), 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule